// File: doc/BRIEF.md
# Private Interrupt Pending Tracker

This block holds the pending state of the 32 private interrupts of one processor. IDs 0-15 are software-generated interrupts (SGIs), raised by request. IDs 16-31 are peripheral interrupts, raised by 16 input lines, with line `i` mapped to ID `16+i`. Each line is sampled every clock into a stored level. A rising edge on a line configured as edge-triggered sets that ID's pending latch. A line configured as level-triggered never sets the latch; instead, its stored level is ORed into the effective pending output.

SGI requests arrive on a valid-only stream. Each request carries a group code, an ID and a non-secure flag. The block has no back-pressure: a request is consumed in the cycle its valid is high, and the response (valid plus accept flag) appears exactly one cycle later and cannot be stalled. Admission works in three steps:
- Remap the requested group.
- Compare it with the interrupt's configured group.
- For non-secure requests while security is enabled, apply a graded 2-bit permission field per SGI.

An admitted request sets the pending latch. Software set and clear strobes per ID act on the latch directly. A clear always wins over any set of the same bit in the same cycle.

Top module: `priv_irq_pend`

## Requirements
- R1: While `rst_n` is low, `pend_latch`, `pend_eff` and `sgi_resp_valid` are 0. Reset clears every latch and every stored line level.
- R2: The stored level of line `i` is `ppi_level[i]` from the previous clock. A line held at a steady value causes no change in state: after its latch is cleared, a line held high does not set it again.
- R3: A 0-to-1 change of a line with `cfg_edge[i]=1` sets `pend_latch[16+i]` at the next clock edge. A 1-to-0 change sets nothing.
- R4: A line with `cfg_edge[i]=0` never sets `pend_latch[16+i]`. For such a line, `pend_eff[16+i] = pend_latch[16+i] | stored level`. For every other bit, `pend_eff` equals `pend_latch`.
- R5: Group codes are 0 = Group 0, 1 = Secure Group 1, 2 = Non-secure Group 1, and 3 = invalid, which is always rejected. The configured group of ID n is 2 if `cfg_grp[n]=1`, 1 if `cfg_grp[n]=0` and `cfg_mod[n]=1`, and otherwise 0. A request with code 1 for an ID configured as Group 0 is handled as a code-0 request.
- R6: After the remapping of R5, a request whose group differs from the configured group is rejected.
- R7: Take a request with `sgi_req_ns=1` while `sec_disable=0`, and let the field be `cfg_ns_acc[2n+1:2n]`. Such a request is rejected for a Group 0 interrupt when the field is below 1, and for a Secure Group 1 interrupt when the field is below 2. Non-secure Group 1 interrupts, secure requests, and any request while `sec_disable=1` skip this check.
- R8: An admitted request sets `pend_latch[n]` at the same clock edge that registers the response. A rejected request changes no latch.
- R9: `sgi_resp_valid` is high exactly in the cycle after `sgi_req_valid` was high. `sgi_resp_accept` then gives the admission result.
- R10: `sw_set[n]` sets `pend_latch[n]` and `sw_clr[n]` clears it at the next edge. A same-cycle clear overrides a software set, an edge set and an admitted SGI set of the same bit. The SGI response still reports the admission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ppi_level | input | 16 | Peripheral interrupt line levels, line i = ID 16+i |
| cfg_edge | input | 16 | 1 = edge-triggered line, 0 = level-triggered |
| cfg_grp | input | 32 | Per-ID group bit (1 = Non-secure Group 1) |
| cfg_mod | input | 32 | Per-ID modifier (1 = Secure Group 1 when group bit is 0) |
| cfg_ns_acc | input | 32 | 2-bit non-secure permission field per SGI, SGI n at bits 2n+1:2n |
| sec_disable | input | 1 | 1 = security disabled, permission check skipped |
| sgi_req_valid | input | 1 | SGI request strobe, always consumed |
| sgi_req_grp | input | 2 | Requested group code |
| sgi_req_id | input | 4 | Requested SGI ID |
| sgi_req_ns | input | 1 | Request originates from the non-secure state |
| sw_set | input | 32 | Software set strobes for the pending latches |
| sw_clr | input | 32 | Software clear strobes (priority over all sets) |
| sgi_resp_valid | output | 1 | Response valid, one cycle after the request |
| sgi_resp_accept | output | 1 | Admission result for the request |
| pend_latch | output | 32 | Pending latch vector |
| pend_eff | output | 32 | Effective pending vector |

## Verification
The assertions check the following on every cycle:
- The response always appears one cycle after a request.
- An accepted SGI is always visible in its latch unless a clear hit it.
- A clear always empties its bit.
- Every qualifying rising edge reaches its latch.
- Group mismatches and inadequate non-secure permission never produce an accept.

Only the bench scenarios can show three things. The first is the full admission table over every combination of requested group, configured group, security flags and permission field. The second is that a level-triggered line leaves its latch empty while still showing as pending. The third is that a steady or falling line sets nothing.

// File: rtl/priv_irq_pkg.sv
package priv_irq_pkg;
  typedef enum logic [1:0] {
    GRP_0    = 2'd0,
    GRP_1S   = 2'd1,
    GRP_1NS  = 2'd2,
    GRP_BAD  = 2'd3
  } grp_e;

  // configured class of one interrupt from its group and modifier bits
  function automatic grp_e cfg_class(input logic grp_bit, input logic mod_bit);
    if (grp_bit) return GRP_1NS;
    if (mod_bit) return GRP_1S;
    return GRP_0;
  endfunction
endpackage

// File: rtl/priv_irq_lvl_track.sv
module priv_irq_lvl_track #(
  parameter int NUM_PPI = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PPI-1:0] level_in,
  input  logic [NUM_PPI-1:0] edge_cfg,
  output logic [NUM_PPI-1:0] level_q,
  output logic [NUM_PPI-1:0] rise
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_in;
  end

  // only a change from the stored level counts; steady input is inert
  assign rise = level_in & ~level_q & edge_cfg;
endmodule

// File: rtl/priv_irq_sgi_admit.sv
module priv_irq_sgi_admit
  import priv_irq_pkg::*;
#(
  parameter int NUM_SGI = 16,
  localparam int IDW = $clog2(NUM_SGI)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_grp,
  input  logic [IDW-1:0]       req_id,
  input  logic                 req_ns,
  input  logic [NUM_SGI-1:0]   grp_cfg,
  input  logic [NUM_SGI-1:0]   mod_cfg,
  input  logic [2*NUM_SGI-1:0] acc_cfg,
  input  logic                 sec_disable,
  output logic [NUM_SGI-1:0]   set_vec,
  output logic                 resp_valid,
  output logic                 resp_accept
);
  grp_e       cls;
  grp_e       req_eff;
  logic [1:0] field;
  logic       match;
  logic       perm_ok;
  logic       admit;

  always_comb begin
    cls     = cfg_class(grp_cfg[req_id], mod_cfg[req_id]);
    req_eff = grp_e'(req_grp);
    if (req_eff == GRP_1S && cls == GRP_0) req_eff = GRP_0;
    match   = (req_eff == cls);
    field   = acc_cfg[{req_id, 1'b0} +: 2];
    perm_ok = 1'b1;
    if (req_ns && !sec_disable) begin
      unique case (cls)
        GRP_0:   perm_ok = (field >= 2'd1);
        GRP_1S:  perm_ok = (field >= 2'd2);
        default: perm_ok = 1'b1;
      endcase
    end
    admit = req_valid && match && perm_ok;
  end

  for (genvar k = 0; k < NUM_SGI; k++) begin : g_set
    assign set_vec[k] = admit && (req_id == IDW'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_accept <= 1'b0;
    end else begin
      resp_valid  <= req_valid;
      resp_accept <= admit;
    end
  end

  p_resp_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  p_no_spurious_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  p_mismatch_rejects_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !match) |=> !resp_accept);
  p_ns_grade_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ns && !sec_disable &&
     ((cls == GRP_1S && field < 2'd2) || (cls == GRP_0 && field == 2'd0)))
    |=> !resp_accept);
endmodule

// File: rtl/priv_irq_latch.sv
module priv_irq_latch #(
  parameter int NIRQ = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] set_vec,
  input  logic [NIRQ-1:0] clr_vec,
  output logic [NIRQ-1:0] q
);
  for (genvar g = 0; g < NIRQ; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bit_q <= 1'b0;
      else if (clr_vec[g]) bit_q <= 1'b0;
      else if (set_vec[g]) bit_q <= 1'b1;
    end
    assign q[g] = bit_q;
  end

  p_clr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((q & $past(clr_vec)) == '0));
endmodule

// File: rtl/priv_irq_pend.sv
module priv_irq_pend #(
  parameter int NUM_SGI = 16,
  parameter int NUM_PPI = 16,
  localparam int NIRQ = NUM_SGI + NUM_PPI,
  localparam int IDW  = $clog2(NUM_SGI)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PPI-1:0]   ppi_level,
  input  logic [NUM_PPI-1:0]   cfg_edge,
  input  logic [NIRQ-1:0]      cfg_grp,
  input  logic [NIRQ-1:0]      cfg_mod,
  input  logic [2*NUM_SGI-1:0] cfg_ns_acc,
  input  logic                 sec_disable,
  input  logic                 sgi_req_valid,
  input  logic [1:0]           sgi_req_grp,
  input  logic [IDW-1:0]       sgi_req_id,
  input  logic                 sgi_req_ns,
  input  logic [NIRQ-1:0]      sw_set,
  input  logic [NIRQ-1:0]      sw_clr,
  output logic                 sgi_resp_valid,
  output logic                 sgi_resp_accept,
  output logic [NIRQ-1:0]      pend_latch,
  output logic [NIRQ-1:0]      pend_eff
);
  logic [NUM_PPI-1:0] lvl_q;
  logic [NUM_PPI-1:0] ppi_rise;
  logic [NUM_SGI-1:0] sgi_set;
  logic [NIRQ-1:0]    set_all;

  priv_irq_lvl_track #(.NUM_PPI(NUM_PPI)) u_lvl (
    .clk(clk), .rst_n(rst_n), .level_in(ppi_level), .edge_cfg(cfg_edge),
    .level_q(lvl_q), .rise(ppi_rise)
  );

  priv_irq_sgi_admit #(.NUM_SGI(NUM_SGI)) u_admit (
    .clk(clk), .rst_n(rst_n), .req_valid(sgi_req_valid), .req_grp(sgi_req_grp),
    .req_id(sgi_req_id), .req_ns(sgi_req_ns),
    .grp_cfg(cfg_grp[NUM_SGI-1:0]), .mod_cfg(cfg_mod[NUM_SGI-1:0]),
    .acc_cfg(cfg_ns_acc), .sec_disable(sec_disable),
    .set_vec(sgi_set), .resp_valid(sgi_resp_valid), .resp_accept(sgi_resp_accept)
  );

  assign set_all = sw_set | {ppi_rise, sgi_set};

  priv_irq_latch #(.NIRQ(NIRQ)) u_latch (
    .clk(clk), .rst_n(rst_n), .set_vec(set_all), .clr_vec(sw_clr), .q(pend_latch)
  );

  assign pend_eff = pend_latch | {lvl_q & ~cfg_edge, {NUM_SGI{1'b0}}};

  p_edge_sets_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ppi_rise & ~sw_clr[NIRQ-1:NUM_SGI])) |=>
    (($past(ppi_rise & ~sw_clr[NIRQ-1:NUM_SGI]) & ~pend_latch[NIRQ-1:NUM_SGI]) == '0));
  p_accept_latches_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sgi_resp_valid && sgi_resp_accept && !$past(sw_clr[sgi_req_id]))
    |-> pend_latch[$past(sgi_req_id)]);
endmodule

// File: tb/sim_priv_irq_pend.sv
`timescale 1ns/1ps
module sim_priv_irq_pend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ppi_level = '0;
  logic [15:0] cfg_edge = '0;
  logic [31:0] cfg_grp = '0;
  logic [31:0] cfg_mod = '0;
  logic [31:0] cfg_ns_acc = '0;
  logic        sec_disable = 1'b0;
  logic        sgi_req_valid = 1'b0;
  logic [1:0]  sgi_req_grp = '0;
  logic [3:0]  sgi_req_id = '0;
  logic        sgi_req_ns = 1'b0;
  logic [31:0] sw_set = '0;
  logic [31:0] sw_clr = '0;
  logic        sgi_resp_valid, sgi_resp_accept;
  logic [31:0] pend_latch, pend_eff;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  priv_irq_pend u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_admit(int rg, int cc, bit ns, bit sd, int fa);
    int g;
    g = (rg == 1 && cc == 0) ? 0 : rg;
    if (g != cc) return 1'b0;
    if (ns && !sd) begin
      if (cc == 0 && fa < 1) return 1'b0;
      if (cc == 1 && fa < 2) return 1'b0;
    end
    return 1'b1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    ppi_level = 16'hFFFF;
    cfg_edge  = 16'hFFFF;
    sw_set    = '1;
    @(negedge clk);
    chk("R1 latch in reset", pend_latch, 32'h0);
    chk("R1 eff in reset", pend_eff, 32'h0);
    chk("R1 resp in reset", {31'h0, sgi_resp_valid}, 32'h0);
    ppi_level = '0; sw_set = '0; cfg_edge = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", pend_eff, 32'h0);

    // SGI admission sweep
    for (int rg = 0; rg < 4; rg++)
      for (int cc = 0; cc < 3; cc++)
        for (int ns = 0; ns < 2; ns++)
          for (int sd = 0; sd < 2; sd++)
            for (int fa = 0; fa < 4; fa++) begin
              int id;
              bit e;
              string tag;
              id = (rg * 7 + cc * 5 + fa * 3 + ns + sd * 2) % 16;
              e = exp_admit(rg, cc, ns[0], sd[0], fa);
              if (rg == 1 && cc == 0) tag = "R5 remap";
              else if (rg != cc) tag = "R6 mismatch";
              else if (ns == 1 && sd == 0 && cc != 2) tag = "R7 ns grade";
              else tag = "R8 admit";
              cfg_grp = '0; cfg_mod = '0; cfg_ns_acc = '0;
              cfg_grp[id] = (cc == 2);
              cfg_mod[id] = (cc == 1);
              cfg_ns_acc[2*id +: 2] = fa[1:0];
              sec_disable = sd[0];
              sgi_req_grp = rg[1:0];
              sgi_req_id = id[3:0];
              sgi_req_ns = ns[0];
              sgi_req_valid = 1'b1;
              @(negedge clk);
              sgi_req_valid = 1'b0;
              chk("R9 resp valid", {31'h0, sgi_resp_valid}, 32'h1);
              chk(tag, {31'h0, sgi_resp_accept}, {31'h0, e});
              chk("R8 latch", pend_latch, e ? (32'h1 << id) : 32'h0);
              sw_clr = '1;
              @(negedge clk);
              sw_clr = '0;
              chk("R9 resp idle", {31'h0, sgi_resp_valid}, 32'h0);
            end

    // peripheral line sweep, even lines edge-triggered
    cfg_edge = 16'h5555;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] b;
      bit ed;
      b = 32'h1 << (16 + i);
      ed = cfg_edge[i];
      ppi_level[i] = 1'b1;
      @(negedge clk);
      chk(ed ? "R3 edge sets" : "R4 level no latch", pend_latch, ed ? b : 32'h0);
      chk("R2 eff high", pend_eff & b, b);
      sw_clr = b;
      @(negedge clk);
      sw_clr = '0;
      chk("R2 steady no reset", pend_latch, 32'h0);
      chk("R4 level eff", pend_eff, ed ? 32'h0 : b);
      ppi_level[i] = 1'b0;
      @(negedge clk);
      chk("R3 fall no set", pend_latch, 32'h0);
      chk("R4 eff low", pend_eff, 32'h0);
    end

    // clear priority
    sw_set = 32'h20; sw_clr = 32'h20;
    @(negedge clk);
    sw_set = 32'h20; sw_clr = '0;
    chk("R10 clr beats sw set", pend_latch, 32'h0);
    @(negedge clk);
    sw_set = '0;
    chk("R10 sw set", pend_latch, 32'h20);
    sw_clr = '1;
    @(negedge clk);
    sw_clr = '0;
    chk("R10 sw clr", pend_latch, 32'h0);

    cfg_grp = '0; cfg_mod = '0; sec_disable = 1'b0;
    sgi_req_grp = 2'd0; sgi_req_id = 4'd3; sgi_req_ns = 1'b0;
    sgi_req_valid = 1'b1; sw_clr = 32'h8;
    @(negedge clk);
    sgi_req_valid = 1'b0; sw_clr = '0;
    chk("R10 sgi accept reported", {31'h0, sgi_resp_accept}, 32'h1);
    chk("R10 clr beats sgi", pend_latch, 32'h0);

    cfg_edge = 16'h0001;
    ppi_level = 16'h0001; sw_clr = 32'h0001_0000;
    @(negedge clk);
    sw_clr = '0;
    chk("R10 clr beats edge", pend_latch, 32'h0);
    ppi_level = '0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule